// File: doc/BRIEF.md
# UART register and status-flag controller

This block is the register layer of an asynchronous serial port. A processor writes bytes into a transmit holding register, and a transmit shifter serializes them. A receive shifter deserializes incoming frames into a receive holding register. A status register reports whether the transmit holder is free, whether unread receive data is waiting, and three sticky receive error flags. Both shifters run at a fixed number of clock cycles per bit, set by a parameter.

The processor accesses the block through a small register window with one write strobe and one read strobe. When several receive errors coincide, a fixed rule decides whether the received byte reaches the holding register: an overrun discards the byte, and a framing or parity error alone does not. A frame that carries any error leaves the receive-full flag as it was before the frame.

Top module: `uart_regflag_ctrl`

## Requirements
- R1: After reset the status register reads tx-empty = 1, rx-full = 0 and all error flags 0, the control register reads 0, and the serial output idles high.
- R2: A write to the transmit data register (address 0) clears tx-empty in the cycle after the write strobe, whatever its earlier value.
- R3: When the transmit shifter is idle and tx-empty is 0, the held byte moves into the shifter on the next clock edge. On that same edge tx-empty becomes 1 and the start bit begins.
- R4: A write to address 0 while tx-empty is 0 replaces the byte that has not yet moved into the shifter. That byte is never transmitted.
- R5: A transmitted frame has one low start bit, the data bits least significant first, an even-parity bit only when control bit 0 is 1, and a high stop bit. Each bit lasts CLKS_PER_BIT cycles.
- R6: An error-free received frame that completes while rx-full is 0 copies its byte into the receive data register and sets rx-full.
- R7: A received frame whose stop bit samples 0 sets the framing flag (status bit 3) and still copies its byte. rx-full keeps its prior value.
- R8: With parity enabled, a received frame whose data and parity bits hold an odd number of ones sets the parity flag (status bit 4) and still copies its byte. A frame with both a parity and a framing error sets both flags and copies the byte. rx-full keeps its prior value.
- R9: A frame that completes while rx-full is 1 sets the overrun flag (status bit 2), leaves the receive data register unchanged, and leaves rx-full at 1. Any framing or parity error in that frame also sets its own flag.
- R10: A read of the receive data register (address 1) clears rx-full, including after an overrun.
- R11: A write to the status register (address 2) clears each error flag whose bit is written 0 and leaves unchanged each flag whose bit is written 1. No other event clears an error flag.
- R12: Address map: 0 transmit data (write), 1 receive data (read), 2 status (bit 0 tx-empty, bit 1 rx-full, bit 2 overrun, bit 3 framing, bit 4 parity), 3 control (bit 0 parity enable, readable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (side effect on address 1 only) |
| addr_i | input | 2 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |

## Verification
Receive frames are applied in every error combination: clean, framing only, parity only, framing plus parity, overrun alone and overrun plus framing. Each combination separates the copy decision from the rx-full decision, because only the overrun cases may leave the old byte in place. On the transmit side, three back-to-back writes during a busy frame show whether the byte not yet loaded is overwritten or kept, and a parity-enabled byte with an odd number of ones shows that the parity bit is inserted. Selective writes to the status register show that each error flag clears on its own.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_PAR,
      PH_STOP
   } phase_e;

   localparam logic [1:0] REG_TXD  = 2'd0;
   localparam logic [1:0] REG_RXD  = 2'd1;
   localparam logic [1:0] REG_STAT = 2'd2;
   localparam logic [1:0] REG_CTRL = 2'd3;

   localparam int ST_TXE = 0;
   localparam int ST_RXF = 1;
   localparam int ST_OVR = 2;
   localparam int ST_FRM = 3;
   localparam int ST_PAR = 4;
endpackage

// File: rtl/uart_rf_tx.sv
module uart_rf_tx
   import uart_rf_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int CLKS_PER_BIT = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              par_on_i,
   output logic              empty_o,
   output logic              line_o
);
   localparam int CNT_W = $clog2(CLKS_PER_BIT);
   localparam int BIT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLKS_PER_BIT - 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

   phase_e            phase;
   logic [DATA_W-1:0] hold;
   logic [DATA_W-1:0] tsr;
   logic              empty;
   logic              par_q;
   logic              pbit;
   logic              line;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  bitn;
   logic              tick;

   assign tick    = (cnt == CNT_LAST);
   assign empty_o = empty;
   assign line_o  = line;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         hold  <= '0;
         tsr   <= '0;
         empty <= 1'b1;
         par_q <= 1'b0;
         pbit  <= 1'b0;
         line  <= 1'b1;
         cnt   <= '0;
         bitn  <= '0;
         phase <= PH_IDLE;
      end else begin
         // holding register and its empty flag; a write always wins
         if (wr_i) begin
            hold  <= wdata_i;
            empty <= 1'b0;
         end else if (phase == PH_IDLE && !empty) begin
            empty <= 1'b1;
         end

         case (phase)
            PH_IDLE: begin
               line <= 1'b1;
               if (!empty) begin
                  tsr   <= hold;
                  pbit  <= ^hold;
                  par_q <= par_on_i;
                  line  <= 1'b0;
                  cnt   <= '0;
                  phase <= PH_START;
               end
            end
            PH_START: begin
               if (tick) begin
                  cnt   <= '0;
                  bitn  <= '0;
                  line  <= tsr[0];
                  phase <= PH_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_DATA: begin
               if (tick) begin
                  cnt <= '0;
                  if (bitn == BIT_LAST) begin
                     phase <= par_q ? PH_PAR : PH_STOP;
                     line  <= par_q ? pbit : 1'b1;
                  end else begin
                     bitn <= bitn + 1'b1;
                     tsr  <= tsr >> 1;
                     line <= tsr[1];
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_PAR: begin
               if (tick) begin
                  cnt   <= '0;
                  line  <= 1'b1;
                  phase <= PH_STOP;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_STOP: begin
               if (tick) begin
                  cnt   <= '0;
                  phase <= PH_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assert_wr_clears_empty_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      wr_i |=> !empty_o);

   assert_load_sets_empty_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (phase == PH_IDLE && !empty_o && !wr_i) |=> (empty_o && !line_o));
endmodule

// File: rtl/uart_rf_rx.sv
module uart_rf_rx
   import uart_rf_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int CLKS_PER_BIT = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              line_i,
   input  logic              par_on_i,
   output logic              done_o,
   output logic [DATA_W-1:0] data_o,
   output logic              frm_err_o,
   output logic              par_err_o
);
   localparam int CNT_W = $clog2(CLKS_PER_BIT);
   localparam int BIT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLKS_PER_BIT - 1);
   localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(CLKS_PER_BIT / 2 - 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

   phase_e            phase;
   logic              s1, s2, prev;
   logic [DATA_W-1:0] sr;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  bitn;
   logic              par_q;
   logic              pbit;
   logic              done, fe, pe;
   logic              tick;

   assign tick      = (cnt == CNT_LAST);
   assign done_o    = done;
   assign data_o    = sr;
   assign frm_err_o = fe;
   assign par_err_o = pe;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         s1    <= 1'b1;
         s2    <= 1'b1;
         prev  <= 1'b1;
         sr    <= '0;
         cnt   <= '0;
         bitn  <= '0;
         par_q <= 1'b0;
         pbit  <= 1'b0;
         done  <= 1'b0;
         fe    <= 1'b0;
         pe    <= 1'b0;
         phase <= PH_IDLE;
      end else begin
         s1   <= line_i;
         s2   <= s1;
         prev <= s2;
         done <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (prev && !s2) begin
                  cnt   <= '0;
                  par_q <= par_on_i;
                  phase <= PH_START;
               end
            end
            PH_START: begin
               if (cnt == CNT_HALF) begin
                  cnt  <= '0;
                  bitn <= '0;
                  phase <= s2 ? PH_IDLE : PH_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_DATA: begin
               if (tick) begin
                  cnt <= '0;
                  sr  <= {s2, sr[DATA_W-1:1]};
                  if (bitn == BIT_LAST) begin
                     phase <= par_q ? PH_PAR : PH_STOP;
                  end else begin
                     bitn <= bitn + 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_PAR: begin
               if (tick) begin
                  cnt   <= '0;
                  pbit  <= s2;
                  phase <= PH_STOP;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            PH_STOP: begin
               if (tick) begin
                  cnt   <= '0;
                  done  <= 1'b1;
                  fe    <= ~s2;
                  pe    <= par_q & (^sr ^ pbit);
                  phase <= PH_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uart_rf_status.sv
module uart_rf_status #(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              done_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              frm_err_i,
   input  logic              par_err_i,
   input  logic              rd_data_i,
   input  logic              clr_wr_i,
   input  logic [2:0]        keep_mask_i,
   output logic [DATA_W-1:0] rxd_o,
   output logic              full_o,
   output logic              ovr_o,
   output logic              frm_o,
   output logic              par_o
);
   logic [DATA_W-1:0] rxd;
   logic              full, ovr, frm, par;
   logic              any_err;
   logic [2:0]        clr;

   assign any_err = frm_err_i | par_err_i;
   assign clr     = clr_wr_i ? ~keep_mask_i : 3'b000;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         rxd  <= '0;
         full <= 1'b0;
         ovr  <= 1'b0;
         frm  <= 1'b0;
         par  <= 1'b0;
      end else begin
         // copy unless the frame overran unread data
         if (done_i && !full) rxd <= data_i;

         if (done_i && !full && !any_err) full <= 1'b1;
         else if (rd_data_i)              full <= 1'b0;

         ovr <= (ovr & ~clr[0]) | (done_i & full);
         frm <= (frm & ~clr[1]) | (done_i & frm_err_i);
         par <= (par & ~clr[2]) | (done_i & par_err_i);
      end
   end

   assign rxd_o  = rxd;
   assign full_o = full;
   assign ovr_o  = ovr;
   assign frm_o  = frm;
   assign par_o  = par;

   assert_clean_copy_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_i && !full_o && !any_err) |=> (full_o && rxd_o == $past(data_i)));

   assert_err_keeps_full_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_i && (any_err || full_o) && !rd_data_i) |=> (full_o == $past(full_o)));

   assert_err_still_copies_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_i && !full_o && any_err) |=> (rxd_o == $past(data_i) && !full_o));

   assert_overrun_blocks_R9: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_i && full_o) |=> ($stable(rxd_o) && ovr_o));

   assert_read_clears_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_data_i && !done_i) |=> !full_o);

   assert_flags_sticky_R11: assert property (@(posedge clk_i) disable iff (rst_i)
      (!done_i && !clr_wr_i) |=> ($stable(ovr_o) && $stable(frm_o) && $stable(par_o)));
endmodule

// File: rtl/uart_regflag_ctrl.sv
module uart_regflag_ctrl
   import uart_rf_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int CLKS_PER_BIT = 8,
   parameter bit PARITY_OPT   = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [1:0]        addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              rx_i,
   output logic              tx_o
);
   initial begin
      if (CLKS_PER_BIT < 4) $error("CLKS_PER_BIT must be at least 4");
      if (DATA_W < 5)       $error("DATA_W must hold the five status bits");
   end

   logic              wr_txd, rd_rxd, wr_stat, wr_ctrl;
   logic              par_on;
   logic              tx_empty;
   logic              rx_done, rx_fe, rx_pe;
   logic [DATA_W-1:0] rx_word;
   logic [DATA_W-1:0] rxd;
   logic              rx_full, f_ovr, f_frm, f_par;

   assign wr_txd  = wr_i && addr_i == REG_TXD;
   assign rd_rxd  = rd_i && addr_i == REG_RXD;
   assign wr_stat = wr_i && addr_i == REG_STAT;
   assign wr_ctrl = wr_i && addr_i == REG_CTRL;

   generate
      if (PARITY_OPT) begin : g_par
         logic ctrl_par;
         always_ff @(posedge clk_i) begin
            if (rst_i)        ctrl_par <= 1'b0;
            else if (wr_ctrl) ctrl_par <= wdata_i[0];
         end
         assign par_on = ctrl_par;
      end else begin : g_nopar
         assign par_on = 1'b0;
      end
   endgenerate

   uart_rf_tx #(.DATA_W(DATA_W), .CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .wr_i     (wr_txd),
      .wdata_i  (wdata_i),
      .par_on_i (par_on),
      .empty_o  (tx_empty),
      .line_o   (tx_o)
   );

   uart_rf_rx #(.DATA_W(DATA_W), .CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .line_i    (rx_i),
      .par_on_i  (par_on),
      .done_o    (rx_done),
      .data_o    (rx_word),
      .frm_err_o (rx_fe),
      .par_err_o (rx_pe)
   );

   uart_rf_status #(.DATA_W(DATA_W)) u_stat (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .done_i      (rx_done),
      .data_i      (rx_word),
      .frm_err_i   (rx_fe),
      .par_err_i   (rx_pe),
      .rd_data_i   (rd_rxd),
      .clr_wr_i    (wr_stat),
      .keep_mask_i ({wdata_i[ST_PAR], wdata_i[ST_FRM], wdata_i[ST_OVR]}),
      .rxd_o       (rxd),
      .full_o      (rx_full),
      .ovr_o       (f_ovr),
      .frm_o       (f_frm),
      .par_o       (f_par)
   );

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         REG_RXD:  rdata_o = rxd;
         REG_STAT: begin
            rdata_o[ST_TXE] = tx_empty;
            rdata_o[ST_RXF] = rx_full;
            rdata_o[ST_OVR] = f_ovr;
            rdata_o[ST_FRM] = f_frm;
            rdata_o[ST_PAR] = f_par;
         end
         REG_CTRL: rdata_o[0] = par_on;
         default:  rdata_o = '0;
      endcase
   end
endmodule

// File: tb/sim_uart_regflag_ctrl.sv
module sim_uart_regflag_ctrl;
   import uart_rf_pkg::*;

   localparam int DW  = 8;
   localparam int CPB = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr = 1'b0, rd = 1'b0;
   logic [1:0]    addr = 2'd0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rx = 1'b1;
   logic          tx;

   always #4 clk = ~clk;

   uart_regflag_ctrl #(.DATA_W(DW), .CLKS_PER_BIT(CPB), .PARITY_OPT(1'b1)) u0 (
      .clk_i(clk), .rst_i(rst), .wr_i(wr), .rd_i(rd), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .rx_i(rx), .tx_o(tx)
   );

   int            n_run = 0;
   int            n_fail = 0;
   int            tx_seen = 0;
   logic [DW-1:0] exp_q[$];
   logic          par_mode = 1'b0;
   logic [DW-1:0] mon_b;
   logic [DW-1:0] mon_e;
   logic          mon_pm;
   logic [DW-1:0] rv;

   task automatic chk_eq(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] st(input bit txe, input bit rxf,
                                        input bit ovr, input bit frm, input bit par);
      logic [DW-1:0] v;
      v = '0;
      v[0] = txe; v[1] = rxf; v[2] = ovr; v[3] = frm; v[4] = par;
      return v;
   endfunction

   task automatic reg_wr(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      addr = a; rd = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic send_frame(input logic [DW-1:0] d, input bit with_par,
                             input bit bad_par, input bit bad_stop);
      @(negedge clk);
      rx = 1'b0;
      repeat (CPB) @(negedge clk);
      for (int i = 0; i < DW; i++) begin
         rx = d[i];
         repeat (CPB) @(negedge clk);
      end
      if (with_par) begin
         rx = (^d) ^ bad_par;
         repeat (CPB) @(negedge clk);
      end
      rx = ~bad_stop;
      repeat (CPB) @(negedge clk);
      rx = 1'b1;
      repeat (2 * CPB) @(negedge clk);
   endtask

   // transmit monitor: decodes tx and compares against the scoreboard queue
   initial begin
      forever begin
         @(negedge clk);
         if (!rst && tx === 1'b0) begin
            mon_pm = par_mode;
            repeat (CPB / 2) @(negedge clk);
            chk_eq("R5 start bit", int'(tx), 0);
            for (int i = 0; i < DW; i++) begin
               repeat (CPB) @(negedge clk);
               mon_b[i] = tx;
            end
            if (mon_pm) begin
               repeat (CPB) @(negedge clk);
               chk_eq("R5 even parity bit", int'(tx), int'(^mon_b));
            end
            repeat (CPB) @(negedge clk);
            chk_eq("R5 stop bit", int'(tx), 1);
            tx_seen++;
            if (exp_q.size() == 0) begin
               chk_eq("R4 unexpected transmitted byte", int'(mon_b), -1);
            end else begin
               mon_e = exp_q.pop_front();
               chk_eq("R4 R5 transmitted byte", int'(mon_b), int'(mon_e));
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      reg_rd(REG_STAT, rv);
      chk_eq("R1 status after reset", int'(rv), int'(st(1, 0, 0, 0, 0)));
      reg_rd(REG_CTRL, rv);
      chk_eq("R1 R12 control after reset", int'(rv), 0);
      chk_eq("R1 idle tx line", int'(tx), 1);

      // R2 / R3 empty flag around a single write
      @(negedge clk);
      addr = REG_TXD; wdata = 8'hA5; wr = 1'b1;
      exp_q.push_back(8'hA5);
      @(negedge clk);
      wr = 1'b0; addr = REG_STAT;
      #1 chk_eq("R2 empty cleared by write", int'(rdata[ST_TXE]), 0);
      @(negedge clk);
      #1 chk_eq("R3 empty set on load", int'(rdata[ST_TXE]), 1);
      chk_eq("R3 start bit on load", int'(tx), 0);
      repeat (12 * CPB) @(negedge clk);

      // R4 overwrite of a byte not yet loaded
      reg_wr(REG_TXD, 8'h3C);
      exp_q.push_back(8'h3C);
      repeat (3) @(negedge clk);
      reg_wr(REG_TXD, 8'hC3);
      reg_rd(REG_STAT, rv);
      chk_eq("R4 pending byte keeps empty low", int'(rv[ST_TXE]), 0);
      reg_wr(REG_TXD, 8'h7E);
      exp_q.push_back(8'h7E);
      repeat (26 * CPB) @(negedge clk);
      chk_eq("R4 scoreboard drained", exp_q.size(), 0);
      chk_eq("R4 frame count", tx_seen, 3);

      // R5 R12 transmit with parity
      reg_wr(REG_CTRL, 8'h01);
      par_mode = 1'b1;
      reg_rd(REG_CTRL, rv);
      chk_eq("R12 control readback", int'(rv), 1);
      reg_wr(REG_TXD, 8'h07);
      exp_q.push_back(8'h07);
      repeat (14 * CPB) @(negedge clk);
      chk_eq("R5 parity frame seen", tx_seen, 4);

      // receive: parity off
      reg_wr(REG_CTRL, 8'h00);
      par_mode = 1'b0;

      send_frame(8'h5A, 0, 0, 0);
      reg_rd(REG_STAT, rv);
      chk_eq("R6 clean frame status", int'(rv), int'(st(1, 1, 0, 0, 0)));
      reg_rd(REG_RXD, rv);
      chk_eq("R6 clean frame data", int'(rv), 8'h5A);
      reg_rd(REG_STAT, rv);
      chk_eq("R10 read clears full", int'(rv), int'(st(1, 0, 0, 0, 0)));

      send_frame(8'h3C, 0, 0, 1);
      reg_rd(REG_STAT, rv);
      chk_eq("R7 framing status", int'(rv), int'(st(1, 0, 0, 1, 0)));
      reg_rd(REG_RXD, rv);
      chk_eq("R7 framing data copied", int'(rv), 8'h3C);
      reg_wr(REG_STAT, 8'h00);
      reg_rd(REG_STAT, rv);
      chk_eq("R11 clear by zero", int'(rv), int'(st(1, 0, 0, 0, 0)));

      // receive: parity on
      reg_wr(REG_CTRL, 8'h01);
      par_mode = 1'b1;
      send_frame(8'h81, 1, 0, 0);
      reg_rd(REG_STAT, rv);
      chk_eq("R6 clean parity frame status", int'(rv), int'(st(1, 1, 0, 0, 0)));
      reg_rd(REG_RXD, rv);
      chk_eq("R6 clean parity frame data", int'(rv), 8'h81);

      send_frame(8'h24, 1, 1, 0);
      reg_rd(REG_STAT, rv);
      chk_eq("R8 parity status", int'(rv), int'(st(1, 0, 0, 0, 1)));
      reg_rd(REG_RXD, rv);
      chk_eq("R8 parity data copied", int'(rv), 8'h24);
      reg_wr(REG_STAT, 8'h00);

      send_frame(8'h66, 1, 1, 1);
      reg_rd(REG_STAT, rv);
      chk_eq("R8 parity plus framing status", int'(rv), int'(st(1, 0, 0, 1, 1)));
      reg_rd(REG_RXD, rv);
      chk_eq("R8 parity plus framing data copied", int'(rv), 8'h66);
      reg_wr(REG_STAT, 8'h00);

      // overrun
      reg_wr(REG_CTRL, 8'h00);
      par_mode = 1'b0;
      send_frame(8'h11, 0, 0, 0);
      send_frame(8'h22, 0, 0, 0);
      reg_rd(REG_STAT, rv);
      chk_eq("R9 overrun status", int'(rv), int'(st(1, 1, 1, 0, 0)));
      reg_rd(REG_RXD, rv);
      chk_eq("R9 overrun keeps old data", int'(rv), 8'h11);
      reg_rd(REG_STAT, rv);
      chk_eq("R10 read after overrun clears full", int'(rv), int'(st(1, 0, 1, 0, 0)));
      reg_wr(REG_STAT, 8'h00);

      send_frame(8'h33, 0, 0, 0);
      send_frame(8'h44, 0, 0, 1);
      reg_rd(REG_STAT, rv);
      chk_eq("R9 overrun plus framing status", int'(rv), int'(st(1, 1, 1, 1, 0)));
      reg_wr(REG_STAT, 8'h04);
      reg_rd(REG_STAT, rv);
      chk_eq("R11 selective clear keeps overrun", int'(rv), int'(st(1, 1, 1, 0, 0)));
      reg_rd(REG_RXD, rv);
      chk_eq("R9 overrun plus framing keeps data", int'(rv), 8'h33);
      reg_wr(REG_STAT, 8'h00);
      reg_rd(REG_STAT, rv);
      chk_eq("R11 R10 final status", int'(rv), int'(st(1, 0, 0, 0, 0)));
      chk_eq("R4 no spurious transmit", tx_seen, 4);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule